// File: doc/BRIEF.md
# Dual Interval Timer With Split-Byte Loading

This block holds two 16-bit down-counting timers that a processor reaches through an 8-bit register window. Each 16-bit value is written one byte at a time. The write of the high byte is what acts on a timer. Reads return the live counters or the reload latch.

The first timer has a full 16-bit reload latch. It runs either once per load or continuously, reloading from the latch each time it passes zero. The second timer keeps only a low latch byte. It counts either clock cycles or falling edges on a pulse input.

The block does not hold the interrupt flag register. It drives one-cycle pulses that set or clear the two flags, and a flag register elsewhere consumes them. The mode bits come in as static inputs from the control register that owns them.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters and all latch bytes are zero, both timers are stopped, all four flag pulse outputs are low, and reads of every address return 0x00.
- R2: A write to address 4 or 6 changes only the low byte of the first timer's latch. The latch high byte and the counter keep their values.
- R3: A write to address 7 stores the first timer's latch high byte and pulses t1_flag_clr in the following cycle. The counter is not reloaded.
- R4: A write to address 5 stores the latch high byte, loads the counter with {written byte, latch low byte}, starts the timer, and pulses t1_flag_clr. The counter holds its loaded value for one clock before the first decrement.
- R5: bus_rdata is combinational from bus_addr, as follows:
  - address 4 and address 5 return the first counter's low and high bytes;
  - address 6 and address 7 return the first latch's low and high bytes;
  - address 8 and address 9 return the second counter's low and high bytes;
  - every other address returns 0x00.
  A read access (bus_sel=1, bus_we=0) at address 4 pulses t1_flag_clr, and one at address 8 pulses t2_flag_clr.
- R6: A running first timer decrements once per clock. In one-shot mode (t1_free_run=0), the step from zero wraps the counter to 0xFFFF and pulses t1_flag_set only once per load. A load of N therefore gives its pulse N+2 clocks after the loading edge.
- R7: In free-run mode (t1_free_run=1), the step from zero reloads the counter from the latch and pulses t1_flag_set every time. With latch value L, the pulses repeat every L+1 clocks.
- R8: A write to address 8 stores the second timer's latch low byte. A write to address 9 pulses t2_flag_clr and re-arms the flag. In timed mode (t2_count_mode=0), the address-9 write also loads the counter with {written byte, latch low byte}, holds it for one clock, then starts counting. In pulse-count mode (t2_count_mode=1), the counter is left unchanged.
- R9: In timed mode a running second timer decrements every clock. t2_flag_set pulses once, on the step that brings the counter from 1 to 0 after an arming write.
- R10: In pulse-count mode the second counter decrements once for each falling edge of t2_pulse_in, meaning a sample of 1 followed by a sample of 0 on successive clocks. It does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| t1_free_run | input | 1 | First timer mode: 1 = free-run, 0 = one-shot |
| t2_count_mode | input | 1 | Second timer mode: 1 = pulse counting, 0 = timed |
| t2_pulse_in | input | 1 | Synchronous pulse input counted in pulse-count mode |
| t1_flag_set | output | 1 | One-cycle pulse: first timer flag set |
| t1_flag_clr | output | 1 | One-cycle pulse: first timer flag clear |
| t2_flag_set | output | 1 | One-cycle pulse: second timer flag set |
| t2_flag_clr | output | 1 | One-cycle pulse: second timer flag clear |

## Verification
The assertions check the following on every cycle:
- the byte placement of latch writes;
- the full counter load on an address-5 write, and the one-clock hold that follows it;
- the clear pulses after high-byte writes and clearing reads;
- that a set pulse only ever follows a counter at zero.

The bench scenarios show the behaviours that span many cycles:
- the exact underflow cycle, and the single pulse per load in one-shot mode;
- the repeat period in free-run mode;
- that a write at address 7 leaves a running counter alone;
- that the second counter stands still with no input edges, and takes no load while in pulse-count mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_T1_CNT_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_T1_CNT_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_T1_LAT_LO = 4'd6;
    localparam logic [ADDR_W-1:0] A_T1_LAT_HI = 4'd7;
    localparam logic [ADDR_W-1:0] A_T2_LO     = 4'd8;
    localparam logic [ADDR_W-1:0] A_T2_HI     = 4'd9;

    // Decoded one-cycle bus commands
    typedef struct packed {
        logic t1_lo_wr;     // address 4 or 6 write
        logic t1_start;     // address 5 write
        logic t1_hi_wr;     // address 7 write
        logic t2_lo_wr;     // address 8 write
        logic t2_hi_wr;     // address 9 write
        logic t1_rd_clr;    // address 4 read
        logic t2_rd_clr;    // address 8 read
    } bus_cmd_t;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_HOLD = 2'd1,
        TS_RUN  = 2'd2
    } tmr_state_t;

    function automatic logic [DATA_W-1:0] byte_of(input logic [CNT_W-1:0] v,
                                                   input logic           hi);
        return hi ? v[CNT_W-1:DATA_W] : v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd
);
    logic wr, rd;

    always_comb begin
        wr = bus_sel & bus_we;
        rd = bus_sel & ~bus_we;
        cmd = '0;
        cmd.t1_lo_wr  = wr & ((bus_addr == A_T1_CNT_LO) | (bus_addr == A_T1_LAT_LO));
        cmd.t1_start  = wr & (bus_addr == A_T1_CNT_HI);
        cmd.t1_hi_wr  = wr & (bus_addr == A_T1_LAT_HI);
        cmd.t2_lo_wr  = wr & (bus_addr == A_T2_LO);
        cmd.t2_hi_wr  = wr & (bus_addr == A_T2_HI);
        cmd.t1_rd_clr = rd & (bus_addr == A_T1_CNT_LO);
        cmd.t2_rd_clr = rd & (bus_addr == A_T2_LO);
    end
endmodule

// File: rtl/tmr_reload_unit.sv
module tmr_reload_unit
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = 2 * DW
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic          start,
    input  logic [DW-1:0] wdata,
    input  logic          free_run,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lat,
    output logic          flag_set
);
    tmr_state_t state;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat      <= '0;
            cnt      <= '0;
            state    <= TS_IDLE;
            armed    <= 1'b0;
            flag_set <= 1'b0;
        end else begin
            flag_set <= 1'b0;
            if (lo_wr)
                lat[DW-1:0] <= wdata;
            if (hi_wr || start)
                lat[CW-1:DW] <= wdata;
            if (start) begin
                cnt   <= {wdata, lat[DW-1:0]};
                state <= TS_HOLD;
                armed <= 1'b1;
            end else begin
                case (state)
                    TS_HOLD: state <= TS_RUN;
                    TS_RUN: begin
                        if (cnt == '0) begin
                            cnt <= free_run ? lat : '1;
                            if (free_run || armed)
                                flag_set <= 1'b1;
                            if (!free_run)
                                armed <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: state <= TS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_interval_unit.sv
module tmr_interval_unit
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = 2 * DW
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic [DW-1:0] wdata,
    input  logic          count_mode,
    input  logic          pulse_in,
    output logic [CW-1:0] cnt,
    output logic          flag_set
);
    tmr_state_t  state;
    logic        armed;
    logic [DW-1:0] lat_lo;
    logic        pulse_q;
    logic        fall;
    logic        step;

    always_comb begin
        fall = pulse_q & ~pulse_in;
        step = count_mode ? fall : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo   <= '0;
            cnt      <= '0;
            state    <= TS_IDLE;
            armed    <= 1'b0;
            pulse_q  <= 1'b0;
            flag_set <= 1'b0;
        end else begin
            flag_set <= 1'b0;
            pulse_q  <= pulse_in;
            if (lo_wr)
                lat_lo <= wdata;
            if (hi_wr) begin
                armed <= 1'b1;
                if (!count_mode) begin
                    cnt   <= {wdata, lat_lo};
                    state <= TS_HOLD;
                end else if (state == TS_IDLE) begin
                    state <= TS_RUN;
                end
            end else begin
                case (state)
                    TS_HOLD: state <= TS_RUN;
                    TS_RUN: begin
                        if (step) begin
                            cnt <= cnt - 1'b1;
                            if (armed && cnt == CW'(1)) begin
                                flag_set <= 1'b1;
                                armed    <= 1'b0;
                            end
                        end
                    end
                    default: state <= TS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              t1_free_run,
    input  logic              t2_count_mode,
    input  logic              t2_pulse_in,
    output logic              t1_flag_set,
    output logic              t1_flag_clr,
    output logic              t2_flag_set,
    output logic              t2_flag_clr
);
    bus_cmd_t         cmd;
    logic [CNT_W-1:0] t1_cnt;
    logic [CNT_W-1:0] t1_lat;
    logic [CNT_W-1:0] t2_cnt;

    tmr_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .cmd      (cmd)
    );

    tmr_reload_unit #(.DW(DATA_W)) u_t1 (
        .clk      (clk),
        .rst      (rst),
        .lo_wr    (cmd.t1_lo_wr),
        .hi_wr    (cmd.t1_hi_wr),
        .start    (cmd.t1_start),
        .wdata    (bus_wdata),
        .free_run (t1_free_run),
        .cnt      (t1_cnt),
        .lat      (t1_lat),
        .flag_set (t1_flag_set)
    );

    tmr_interval_unit #(.DW(DATA_W)) u_t2 (
        .clk        (clk),
        .rst        (rst),
        .lo_wr      (cmd.t2_lo_wr),
        .hi_wr      (cmd.t2_hi_wr),
        .wdata      (bus_wdata),
        .count_mode (t2_count_mode),
        .pulse_in   (t2_pulse_in),
        .cnt        (t2_cnt),
        .flag_set   (t2_flag_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_flag_clr <= 1'b0;
            t2_flag_clr <= 1'b0;
        end else begin
            t1_flag_clr <= cmd.t1_start | cmd.t1_hi_wr | cmd.t1_rd_clr;
            t2_flag_clr <= cmd.t2_hi_wr | cmd.t2_rd_clr;
        end
    end

    always_comb begin
        case (bus_addr)
            A_T1_CNT_LO: bus_rdata = byte_of(t1_cnt, 1'b0);
            A_T1_CNT_HI: bus_rdata = byte_of(t1_cnt, 1'b1);
            A_T1_LAT_LO: bus_rdata = byte_of(t1_lat, 1'b0);
            A_T1_LAT_HI: bus_rdata = byte_of(t1_lat, 1'b1);
            A_T2_LO:     bus_rdata = byte_of(t2_cnt, 1'b0);
            A_T2_HI:     bus_rdata = byte_of(t2_cnt, 1'b1);
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  t1_cnt,
    input logic [CNT_W-1:0]  t1_lat,
    input logic [CNT_W-1:0]  t2_cnt,
    input logic              t1_flag_set,
    input logic              t1_flag_clr,
    input logic              t2_flag_set,
    input logic              t2_flag_clr
);
    logic w4or6, w5, w7, w9, rd4, rd8;
    assign w4or6 = bus_sel && bus_we && (bus_addr == 4'd4 || bus_addr == 4'd6);
    assign w5    = bus_sel && bus_we && bus_addr == 4'd5;
    assign w7    = bus_sel && bus_we && bus_addr == 4'd7;
    assign w9    = bus_sel && bus_we && bus_addr == 4'd9;
    assign rd4   = bus_sel && !bus_we && bus_addr == 4'd4;
    assign rd8   = bus_sel && !bus_we && bus_addr == 4'd8;

    // R2: low-byte writes leave the latch high byte alone
    a_r2_low_byte_only: assert property (@(posedge clk) disable iff (rst)
        w4or6 |=> (t1_lat[DATA_W-1:0] == $past(bus_wdata)) &&
                  (t1_lat[CNT_W-1:DATA_W] == $past(t1_lat[CNT_W-1:DATA_W])));

    // R3: latch high write stores the byte and clears the flag
    a_r3_latch_hi_clear: assert property (@(posedge clk) disable iff (rst)
        w7 |=> (t1_lat[CNT_W-1:DATA_W] == $past(bus_wdata)) && t1_flag_clr);

    // R4: start write loads the full counter
    a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
        w5 |=> (t1_cnt == {$past(bus_wdata), $past(t1_lat[DATA_W-1:0])}) && t1_flag_clr);

    // R4: one clock of hold after the load
    a_r4_hold_one_clock: assert property (@(posedge clk) disable iff (rst)
        (w5 ##1 !w5) |=> $stable(t1_cnt));

    // R5: clearing reads
    a_r5_read_clear: assert property (@(posedge clk) disable iff (rst)
        rd4 |=> t1_flag_clr);
    a_r5_read_clear_t2: assert property (@(posedge clk) disable iff (rst)
        rd8 |=> t2_flag_clr);

    // R6: a set pulse only follows a counter that stood at zero
    a_r6_underflow_from_zero: assert property (@(posedge clk) disable iff (rst)
        t1_flag_set |-> $past(t1_cnt) == '0);

    // R8: address-9 write clears the second flag
    a_r8_t2_hi_clear: assert property (@(posedge clk) disable iff (rst)
        w9 |=> t2_flag_clr);

    // R9: second set pulse arrives with the counter at zero
    a_r9_t2_at_zero: assert property (@(posedge clk) disable iff (rst)
        t2_flag_set |-> t2_cnt == '0);
endmodule

bind dual_interval_timer dual_interval_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .t1_cnt      (t1_cnt),
    .t1_lat      (t1_lat),
    .t2_cnt      (t2_cnt),
    .t1_flag_set (t1_flag_set),
    .t1_flag_clr (t1_flag_clr),
    .t2_flag_set (t2_flag_set),
    .t2_flag_clr (t2_flag_clr)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       t1_free_run = 1'b0;
    logic       t2_count_mode = 1'b0;
    logic       t2_pulse_in = 1'b0;
    logic       t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_interval_timer u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .t1_free_run(t1_free_run), .t2_count_mode(t2_count_mode),
        .t2_pulse_in(t2_pulse_in), .t1_flag_set(t1_flag_set),
        .t1_flag_clr(t1_flag_clr), .t2_flag_set(t2_flag_set),
        .t2_flag_clr(t2_flag_clr)
    );

    // Vector: [24:21] requirement number, [20] write, [19:16] addr,
    // [15:8] write data, [7:0] expected read data
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2, 1'b1, 4'd6, 8'h34, 8'h00},   // R2 latch low via address 6
        {4'd3, 1'b1, 4'd7, 8'h12, 8'h00},   // R3 latch high, no reload
        {4'd5, 1'b0, 4'd6, 8'h00, 8'h34},   // R5 latch low read
        {4'd5, 1'b0, 4'd7, 8'h00, 8'h12},   // R5 latch high read
        {4'd3, 1'b0, 4'd5, 8'h00, 8'h00},   // R3 counter untouched
        {4'd2, 1'b1, 4'd4, 8'h56, 8'h00},   // R2 latch low via address 4
        {4'd2, 1'b0, 4'd6, 8'h00, 8'h56},   // R2 latch low updated
        {4'd2, 1'b0, 4'd4, 8'h00, 8'h00},   // R2 counter untouched
        {4'd8, 1'b1, 4'd8, 8'hAB, 8'h00},   // R8 second latch low
        {4'd8, 1'b0, 4'd8, 8'h00, 8'h00},   // R8 no counter load
        {4'd5, 1'b0, 4'd3, 8'h00, 8'h00},   // R5 unmapped address
        {4'd5, 1'b0, 4'd7, 8'h00, 8'h12}    // R5 latch high kept
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int npulse, first;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(4'd4, rd);
        check(rd == 8'h00, "R1", "counter low after reset", rd, 0);
        peek(4'd7, rd);
        check(rd == 8'h00, "R1", "latch high after reset", rd, 0);
        check({t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr} == 4'b0,
              "R1", "pulse outputs after reset",
              {t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                bus_write(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][19:16], rd);
                checks++;
                if (rd != VEC[i][7:0]) begin
                    failures++;
                    $display("FAIL R%0d vector %0d addr %0d actual=%0h expected=%0h",
                             VEC[i][24:21], i, VEC[i][19:16], rd, VEC[i][7:0]);
                end
            end
        end

        // R4 / R6: one-shot, latch 0x0003
        bus_write(4'd6, 8'h03);
        bus_write(4'd5, 8'h00);
        check(t1_flag_clr == 1'b1, "R4", "clear pulse on start", t1_flag_clr, 1);
        bus_addr = 4'd4;
        npulse = 0; first = 0;
        for (int k = 1; k <= 30; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 1) check(bus_rdata == 8'h03, "R4", "hold after load", bus_rdata, 3);
            if (k == 2) check(bus_rdata == 8'h02, "R6", "first decrement", bus_rdata, 2);
            if (k == 5) check(bus_rdata == 8'hFF, "R6", "one-shot wrap", bus_rdata, 8'hFF);
            if (t1_flag_set) begin
                npulse++;
                if (first == 0) first = k;
            end
        end
        check(first == 5, "R6", "one-shot pulse cycle", first, 5);
        check(npulse == 1, "R6", "one-shot pulse count", npulse, 1);

        // R5 clearing read at address 4
        bus_read(4'd4, rd);
        check(t1_flag_clr == 1'b1, "R5", "read 4 clear pulse", t1_flag_clr, 1);

        // R7: free-run, period 4
        t1_free_run = 1'b1;
        bus_write(4'd5, 8'h00);
        bus_addr = 4'd4;
        npulse = 0; first = 0;
        for (int k = 1; k <= 14; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 5) check(bus_rdata == 8'h03, "R7", "reload from latch", bus_rdata, 3);
            if (t1_flag_set) begin
                npulse++;
                if (first == 0) first = k;
            end
        end
        check(first == 5, "R7", "free-run first pulse", first, 5);
        check(npulse == 3, "R7", "free-run pulse count", npulse, 3);

        // R3: address-7 write while running does not reload
        bus_write(4'd7, 8'h40);
        check(t1_flag_clr == 1'b1, "R3", "clear pulse on write 7", t1_flag_clr, 1);
        peek(4'd5, rd);
        check(rd == 8'h00, "R3", "counter high not reloaded", rd, 0);
        peek(4'd7, rd);
        check(rd == 8'h40, "R3", "latch high stored", rd, 8'h40);
        t1_free_run = 1'b0;

        // R8 / R9: timed second timer, load 2
        t2_count_mode = 1'b0;
        bus_write(4'd8, 8'h02);
        bus_write(4'd9, 8'h00);
        check(t2_flag_clr == 1'b1, "R8", "clear pulse on write 9", t2_flag_clr, 1);
        npulse = 0; first = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (t2_flag_set) begin
                npulse++;
                if (first == 0) first = k;
            end
        end
        check(first == 3, "R9", "timed pulse cycle", first, 3);
        check(npulse == 1, "R9", "timed pulse count", npulse, 1);

        // R10: pulse counting from 3
        bus_write(4'd8, 8'h03);
        bus_write(4'd9, 8'h00);
        t2_count_mode = 1'b1;
        t2_pulse_in = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        peek(4'd8, rd);
        check(rd == 8'h03, "R10", "no edges no count", rd, 3);
        for (int e = 1; e <= 3; e++) begin
            t2_pulse_in = 1'b1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            t2_pulse_in = 1'b0;
            @(posedge clk); @(negedge clk);
            check(t2_flag_set == (e == 3), "R10", "pulse after edge", t2_flag_set, (e == 3));
            peek(4'd8, rd);
            check(rd == 8'(3 - e), "R10", "count after edge", rd, 3 - e);
            repeat (2) @(posedge clk);
            @(negedge clk);
        end
        t2_pulse_in = 1'b1;

        // R8: no load in pulse-count mode
        bus_write(4'd8, 8'h05);
        bus_write(4'd9, 8'h07);
        check(t2_flag_clr == 1'b1, "R8", "clear pulse count mode", t2_flag_clr, 1);
        peek(4'd9, rd);
        check(rd == 8'h00, "R8", "count mode no load high", rd, 0);
        peek(4'd8, rd);
        check(rd == 8'h00, "R8", "count mode no load low", rd, 0);

        // R5 clearing read at address 8
        bus_read(4'd8, rd);
        check(t2_flag_clr == 1'b1, "R5", "read 8 clear pulse", t2_flag_clr, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule